// File: doc/BRIEF.md
# Mixed-Polarity Interrupt Combiner

This block gathers a fixed set of external interrupt pins, an 8-bit general-purpose port and two wake pins, and drives two processor interrupt lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Each numbered input has a fixed active polarity and a fixed trigger type. The inputs are either latched on an edge or followed as a level. Each input also has a fixed set of outputs it is allowed to reach. Every pin passes through a two-flop synchronizer and is then converted to an active-high form before any decision is made.

Software uses a small word-wide register bus with one write strobe and a combinational read. Each interrupt bank has its own pending, clear, enable and masked-request views. A raw view gives the synchronized levels of input 1, the two open-drain pins and the port. Further registers drive the port output value, the port output enables and the open-drain pull-down controls. Three inputs are present in both banks, so the two enable registers decide whether each of them raises the normal request, the fast request or both.

A falling edge on either active-low event pin produces a one-cycle wake pulse. A power controller uses this pulse to leave its stop or suspend state.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `fiq_o` and `wake_o` are low. Both enable registers, the port output-enable register and the open-drain control register read 0. With all pins idle, both pending views read 0.
- R2: A falling edge on `nint1_i` sets normal-bank pending bit 0. The bit stays set after the pin returns high. Writing a word to the normal clear register (address 1) clears exactly the bits that hold 1 in that word. Raw view (address 8) bit 0 shows the synchronized level of `nint1_i`.
- R3: A rising edge on `int2_i` sets normal-bank pending bit 1. The bit stays set until it is cleared as in R2. This input never appears in the fast bank (address 4).
- R4: The level sources appear in the normal bank (address 0) as follows: `nint3_i` in bit 2 (active low), `nint4_i` in bit 3 (active low) and `int7_i` in bit 6 (active high). Each bit follows its pin, and a clear write has no effect on it.
- R5: `int5_i` (active high), `nint6_i` (active low) and `nint8_i` (active low) appear in normal-bank bits 4, 5 and 7 and in fast-bank bits 0, 1 and 2. The normal enable register (address 2) and the fast enable register (address 6) choose which output each of them raises.
- R6: `int9_i` (active high) appears only in fast-bank bit 3. The fast bank has 4 bits, so the fast enable register keeps only bits 3:0 of a written word, and fast-bank bits 15:4 read 0.
- R7: Port pin `port_i[k]` is an active-high level source in normal-bank bit 8+k and shows in raw-view bit 8+k. Register 9 drives `port_o` and register 10 drives `port_oe_o`.
- R8: The open-drain pins are never interrupt sources. Their synchronized levels read in raw-view bits 2:1, and register 11 bits 1:0 drive `od_low_o`.
- R9: Address 3 reads normal pending AND normal enable, and address 7 reads fast pending AND fast enable. `irq_o` and `fiq_o` are the registered OR of these words, so each follows its word one cycle later.
- R10: Each falling edge on `nevent1_i` or `nevent2_i` gives exactly one cycle of `wake_o`. A rising edge on these pins gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nint1_i | input | 1 | Falling-edge interrupt, active low |
| int2_i | input | 1 | Rising-edge interrupt |
| nint3_i | input | 1 | Level interrupt, active low |
| nint4_i | input | 1 | Level interrupt, active low |
| int5_i | input | 1 | Routable level interrupt, active high |
| nint6_i | input | 1 | Routable level interrupt, active low |
| int7_i | input | 1 | Level interrupt, active high |
| nint8_i | input | 1 | Routable level interrupt, active low |
| int9_i | input | 1 | Fast-only level interrupt, active high |
| nevent1_i | input | 1 | Wake event pin, active low |
| nevent2_i | input | 1 | Wake event pin, active low |
| port_i | input | 8 | General-purpose port levels |
| port_o | output | 8 | General-purpose port output value |
| port_oe_o | output | 8 | General-purpose port output enables |
| od_i | input | 2 | Open-drain pin levels |
| od_low_o | output | 2 | Open-drain pull-down controls |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The wake check assumes that an event pin holds each level for at least one clock. It also assumes that the two event pins never fall in consecutive cycles, so each pulse can be traced back to the pin change that caused it. The request checks need the event and level pins to be quiet during reset. The stimulus changes pins only on the falling clock edge and holds each pattern for several cycles, so every edge passes the synchronizer. It drops the event pins one at a time, far apart, and keeps them high through reset.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
  localparam int DW      = 16;
  localparam int AW      = 4;
  localparam int PORT_W  = 8;
  localparam int OD_W    = 2;
  localparam int NLINE   = 9;
  localparam int NEV     = 2;
  localparam int P_EV0   = NLINE;
  localparam int P_PORT0 = NLINE + NEV;
  localparam int P_OD0   = P_PORT0 + PORT_W;
  localparam int NPIN    = P_OD0 + OD_W;
  localparam int NEDGE   = NLINE + NEV;
  localparam int IRQ_W   = 8 + PORT_W;
  localparam int FIQ_W   = 4;

  // line indices of the numbered inputs (input n sits at n-1)
  localparam int L_IN5 = 4;
  localparam int L_IN6 = 5;
  localparam int L_IN8 = 7;
  localparam int L_IN9 = 8;

  // active-low numbered inputs: 1,3,4,6,8
  localparam logic [NLINE-1:0] LINE_LOW = 9'b010101101;
  localparam logic [NPIN-1:0]  ACT_LOW  = {{OD_W{1'b0}}, {PORT_W{1'b0}}, {NEV{1'b1}}, LINE_LOW};
  localparam logic [NPIN-1:0]  PIN_IDLE = {{OD_W{1'b1}}, {PORT_W{1'b0}}, {NEV{1'b1}}, LINE_LOW};
  localparam logic [IRQ_W-1:0] IRQ_EDGE = {{(IRQ_W-2){1'b0}}, 2'b11};
  localparam logic [FIQ_W-1:0] FIQ_EDGE = '0;

  typedef enum logic [AW-1:0] {
    RA_IRQ_PEND = 4'd0,
    RA_IRQ_CLR  = 4'd1,
    RA_IRQ_EN   = 4'd2,
    RA_IRQ_REQ  = 4'd3,
    RA_FIQ_PEND = 4'd4,
    RA_FIQ_CLR  = 4'd5,
    RA_FIQ_EN   = 4'd6,
    RA_FIQ_REQ  = 4'd7,
    RA_RAW      = 4'd8,
    RA_PORT_OUT = 4'd9,
    RA_PORT_OE  = 4'd10,
    RA_OD_CTRL  = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/mpirq_sync.sv
module mpirq_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/mpirq_bank.sv
module mpirq_bank #(
  parameter int           W         = 8,
  parameter logic [W-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic unused_sink;
  assign unused_sink = &{1'b0, clk, rst_n, act_i, rise_i, clr_i};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic hit_q;
      logic hit_d;
      // a new edge in the same cycle as a clear keeps the bit set
      always_comb hit_d = (hit_q & ~clr_i[i]) | rise_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
      end
      assign pend_o[i] = hit_q;
    end else begin : g_lvl
      assign pend_o[i] = act_i[i];
    end
  end
endmodule

// File: rtl/mpirq_regs.sv
module mpirq_regs
  import mpirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [IRQ_W-1:0]  irq_pend_i,
  input  logic [FIQ_W-1:0]  fiq_pend_i,
  input  logic [DW-1:0]     raw_i,
  output logic [DW-1:0]     rdata_o,
  output logic [IRQ_W-1:0]  irq_en_o,
  output logic [FIQ_W-1:0]  fiq_en_o,
  output logic [IRQ_W-1:0]  irq_clr_o,
  output logic [FIQ_W-1:0]  fiq_clr_o,
  output logic [PORT_W-1:0] port_out_o,
  output logic [PORT_W-1:0] port_oe_o,
  output logic [OD_W-1:0]   od_low_o
);
  logic [IRQ_W-1:0]  irq_en_q;
  logic [FIQ_W-1:0]  fiq_en_q;
  logic [PORT_W-1:0] port_out_q;
  logic [PORT_W-1:0] port_oe_q;
  logic [OD_W-1:0]   od_low_q;

  logic irq_en_we, fiq_en_we, port_out_we, port_oe_we, od_we;
  logic irq_clr_we, fiq_clr_we;

  always_comb begin
    irq_en_we   = wr_i && (addr_i == RA_IRQ_EN);
    fiq_en_we   = wr_i && (addr_i == RA_FIQ_EN);
    port_out_we = wr_i && (addr_i == RA_PORT_OUT);
    port_oe_we  = wr_i && (addr_i == RA_PORT_OE);
    od_we       = wr_i && (addr_i == RA_OD_CTRL);
    irq_clr_we  = wr_i && (addr_i == RA_IRQ_CLR);
    fiq_clr_we  = wr_i && (addr_i == RA_FIQ_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= '0;
      fiq_en_q   <= '0;
      port_out_q <= '0;
      port_oe_q  <= '0;
      od_low_q   <= '0;
    end else begin
      if (irq_en_we)   irq_en_q   <= wdata_i[IRQ_W-1:0];
      if (fiq_en_we)   fiq_en_q   <= wdata_i[FIQ_W-1:0];
      if (port_out_we) port_out_q <= wdata_i[PORT_W-1:0];
      if (port_oe_we)  port_oe_q  <= wdata_i[PORT_W-1:0];
      if (od_we)       od_low_q   <= wdata_i[OD_W-1:0];
    end
  end

  assign irq_clr_o  = irq_clr_we ? wdata_i[IRQ_W-1:0] : '0;
  assign fiq_clr_o  = fiq_clr_we ? wdata_i[FIQ_W-1:0] : '0;
  assign irq_en_o   = irq_en_q;
  assign fiq_en_o   = fiq_en_q;
  assign port_out_o = port_out_q;
  assign port_oe_o  = port_oe_q;
  assign od_low_o   = od_low_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_IRQ_PEND: rdata_o[IRQ_W-1:0]  = irq_pend_i;
      RA_IRQ_EN:   rdata_o[IRQ_W-1:0]  = irq_en_q;
      RA_IRQ_REQ:  rdata_o[IRQ_W-1:0]  = irq_pend_i & irq_en_q;
      RA_FIQ_PEND: rdata_o[FIQ_W-1:0]  = fiq_pend_i;
      RA_FIQ_EN:   rdata_o[FIQ_W-1:0]  = fiq_en_q;
      RA_FIQ_REQ:  rdata_o[FIQ_W-1:0]  = fiq_pend_i & fiq_en_q;
      RA_RAW:      rdata_o             = raw_i;
      RA_PORT_OUT: rdata_o[PORT_W-1:0] = port_out_q;
      RA_PORT_OE:  rdata_o[PORT_W-1:0] = port_oe_q;
      RA_OD_CTRL:  rdata_o[OD_W-1:0]   = od_low_q;
      default:     rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
  import mpirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nint1_i,
  input  logic              int2_i,
  input  logic              nint3_i,
  input  logic              nint4_i,
  input  logic              int5_i,
  input  logic              nint6_i,
  input  logic              int7_i,
  input  logic              nint8_i,
  input  logic              int9_i,
  input  logic              nevent1_i,
  input  logic              nevent2_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [PORT_W-1:0] port_o,
  output logic [PORT_W-1:0] port_oe_o,
  input  logic [OD_W-1:0]   od_i,
  output logic [OD_W-1:0]   od_low_o,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // pin capture and polarity normalisation
  logic [NPIN-1:0] pin_raw_w, pin_s_w, act_w;
  logic [NEDGE-1:0] prev_q, rise_w;

  assign pin_raw_w = {od_i, port_i, nevent2_i, nevent1_i, int9_i, nint8_i, int7_i,
                      nint6_i, int5_i, nint4_i, nint3_i, int2_i, nint1_i};

  mpirq_sync #(.W(NPIN), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pin_raw_w),
    .q_o   (pin_s_w)
  );

  assign act_w = pin_s_w ^ ACT_LOW;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) prev_q <= '0;
    else             prev_q <= act_w[NEDGE-1:0];
  end
  assign rise_w = act_w[NEDGE-1:0] & ~prev_q;

  logic unused_top;
  assign unused_top = &{1'b0, rise_w[L_IN9], act_w[P_OD0 +: OD_W]};

  // source banks
  logic [IRQ_W-1:0] irq_act_w, irq_rise_w, irq_pend_w, irq_en_w, irq_clr_w;
  logic [FIQ_W-1:0] fiq_act_w, fiq_pend_w, fiq_en_w, fiq_clr_w;

  assign irq_act_w  = {act_w[P_PORT0 +: PORT_W], act_w[7:0]};
  assign irq_rise_w = {{PORT_W{1'b0}}, rise_w[7:0]};
  assign fiq_act_w  = {act_w[L_IN9], act_w[L_IN8], act_w[L_IN6], act_w[L_IN5]};

  mpirq_bank #(.W(IRQ_W), .EDGE_MASK(IRQ_EDGE)) u_irq_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act_i  (irq_act_w),
    .rise_i (irq_rise_w),
    .clr_i  (irq_clr_w),
    .pend_o (irq_pend_w)
  );

  mpirq_bank #(.W(FIQ_W), .EDGE_MASK(FIQ_EDGE)) u_fiq_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act_i  (fiq_act_w),
    .rise_i ('0),
    .clr_i  (fiq_clr_w),
    .pend_o (fiq_pend_w)
  );

  // register file
  logic [DW-1:0] raw_view_w;
  assign raw_view_w = {pin_s_w[P_PORT0 +: PORT_W], {(DW-PORT_W-OD_W-1){1'b0}},
                       pin_s_w[P_OD0 +: OD_W], pin_s_w[0]};

  mpirq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .wdata_i    (bus_wdata_i),
    .irq_pend_i (irq_pend_w),
    .fiq_pend_i (fiq_pend_w),
    .raw_i      (raw_view_w),
    .rdata_o    (bus_rdata_o),
    .irq_en_o   (irq_en_w),
    .fiq_en_o   (fiq_en_w),
    .irq_clr_o  (irq_clr_w),
    .fiq_clr_o  (fiq_clr_w),
    .port_out_o (port_o),
    .port_oe_o  (port_oe_o),
    .od_low_o   (od_low_o)
  );

  // output stage
  logic irq_d, fiq_d, wake_d;
  logic irq_q, fiq_q, wake_q;

  always_comb begin
    irq_d  = |(irq_pend_w & irq_en_w);
    fiq_d  = |(fiq_pend_w & fiq_en_w);
    wake_d = |rise_w[P_EV0 +: NEV];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q  <= 1'b0;
      fiq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      fiq_q  <= fiq_d;
      wake_q <= wake_d;
    end
  end

  assign irq_o  = irq_q;
  assign fiq_o  = fiq_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/mpirq_ctrl_chk.sv
module mpirq_ctrl_chk
  import mpirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             wake_o,
  input logic [IRQ_W-1:0] irq_pend,
  input logic [IRQ_W-1:0] irq_en,
  input logic [IRQ_W-1:0] irq_clr,
  input logic [FIQ_W-1:0] fiq_pend,
  input logic [FIQ_W-1:0] fiq_en,
  input logic             nev1,
  input logic             nev2
);
  logic [2:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 3'd5)  cyc_q <= cyc_q + 3'd1;
  end

  AST_IRQ_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(irq_pend & irq_en))); // R9

  AST_FIQ_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|(fiq_pend & fiq_en))); // R9

  AST_EDGE1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend[0] && !irq_clr[0]) |=> irq_pend[0]); // R2

  AST_EDGE2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend[1] && !irq_clr[1]) |=> irq_pend[1]); // R3

  AST_WAKE_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && cyc_q == 3'd5) |->
      (($past(nev1, 4) && !$past(nev1, 3)) || ($past(nev2, 4) && !$past(nev2, 3)))); // R10
endmodule

bind mpirq_ctrl mpirq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .wake_o   (wake_o),
  .irq_pend (irq_pend_w),
  .irq_en   (irq_en_w),
  .irq_clr  (irq_clr_w),
  .fiq_pend (fiq_pend_w),
  .fiq_en   (fiq_en_w),
  .nev1     (nevent1_i),
  .nev2     (nevent2_i)
);

// File: tb/mpirq_ctrl_tb.sv
`timescale 1ns/1ps
module mpirq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic n1, i2, n3, n4, i5, n6, i7, n8, i9, ev1, ev2;
  logic [7:0]  port_in;
  logic [7:0]  port_out, port_oe;
  logic [1:0]  od_in, od_low;
  logic [3:0]  addr;
  logic        wr;
  logic [15:0] wdata, rdata;
  logic        irq, fiq, wake;

  int checks = 0;
  int errors = 0;
  logic e1_exp, e2_exp;

  always #5 clk = ~clk;

  mpirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .nint1_i(n1), .int2_i(i2), .nint3_i(n3), .nint4_i(n4), .int5_i(i5),
    .nint6_i(n6), .int7_i(i7), .nint8_i(n8), .int9_i(i9),
    .nevent1_i(ev1), .nevent2_i(ev2),
    .port_i(port_in), .port_o(port_out), .port_oe_o(port_oe),
    .od_i(od_in), .od_low_o(od_low),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_irq();
    return {port_in, ~n8, i7, ~n6, i5, ~n4, ~n3, e2_exp, e1_exp};
  endfunction

  function automatic logic [15:0] exp_fiq();
    return {12'h000, i9, ~n8, ~n6, i5};
  endfunction

  task automatic pins_idle();
    n1 = 1; i2 = 0; n3 = 1; n4 = 1; i5 = 0; n6 = 1; i7 = 0; n8 = 1; i9 = 0;
    port_in = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int wcnt;
    void'($urandom(32'd4242));
    rst_n = 0; pins_idle(); ev1 = 1; ev2 = 1; od_in = 2'b11;
    addr = 0; wr = 0; wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    settle(6);

    // R1 reset state
    chk("R1 irq_o", irq, 0);
    chk("R1 fiq_o", fiq, 0);
    chk("R1 wake_o", wake, 0);
    rd_reg(4'd0, d); chk("R1 irq pend", d, 0);
    rd_reg(4'd4, d); chk("R1 fiq pend", d, 0);
    rd_reg(4'd2, d); chk("R1 irq en", d, 0);
    rd_reg(4'd6, d); chk("R1 fiq en", d, 0);
    rd_reg(4'd10, d); chk("R1 port oe", d, 0);
    rd_reg(4'd11, d); chk("R1 od ctrl", d, 0);

    // R2 falling edge on input 1, sticky, selective clear, raw level
    @(negedge clk); n1 = 0; settle(6);
    rd_reg(4'd8, d); chk("R2 raw n1 low", d[0], 0);
    @(negedge clk); n1 = 1; settle(6);
    rd_reg(4'd8, d); chk("R2 raw n1 high", d[0], 1);
    rd_reg(4'd0, d); chk("R2 pend sticky", d, 16'h0001);
    wr_reg(4'd2, 16'h0001); settle(2);
    chk("R9 irq on enabled edge", irq, 1);
    rd_reg(4'd3, d); chk("R9 irq req view", d, 16'h0001);
    wr_reg(4'd1, 16'h0002); settle(1);
    rd_reg(4'd0, d); chk("R2 clear other bit keeps", d, 16'h0001);
    wr_reg(4'd1, 16'h0001); settle(2);
    rd_reg(4'd0, d); chk("R2 cleared", d, 0);
    chk("R9 irq drops", irq, 0);

    // R3 rising edge on input 2
    @(negedge clk); i2 = 1; settle(6);
    @(negedge clk); i2 = 0; settle(6);
    rd_reg(4'd0, d); chk("R3 pend bit1", d, 16'h0002);
    rd_reg(4'd4, d); chk("R3 not in fast bank", d, 0);
    wr_reg(4'd1, 16'hFFFF); settle(1);

    // R4 levels, not clearable
    @(negedge clk); n3 = 0; i7 = 1; settle(6);
    rd_reg(4'd0, d); chk("R4 levels set", d, 16'h0044);
    wr_reg(4'd1, 16'hFFFF); settle(1);
    rd_reg(4'd0, d); chk("R4 clear ignored", d, 16'h0044);
    @(negedge clk); n3 = 1; i7 = 0; n4 = 0; settle(6);
    rd_reg(4'd0, d); chk("R4 follows pins", d, 16'h0008);
    @(negedge clk); n4 = 1; settle(6);

    // R5 routing by enables
    wr_reg(4'd2, 16'h0000); wr_reg(4'd6, 16'h0001);
    @(negedge clk); i5 = 1; settle(6);
    chk("R5 in5 to fast", fiq, 1);
    chk("R5 in5 not normal", irq, 0);
    wr_reg(4'd2, 16'h0010); wr_reg(4'd6, 16'h0000); settle(2);
    chk("R5 in5 to normal", irq, 1);
    chk("R5 in5 off fast", fiq, 0);
    @(negedge clk); i5 = 0; n6 = 0; n8 = 0; settle(6);
    rd_reg(4'd4, d); chk("R5 fast pend 6/8", d, 16'h0006);
    rd_reg(4'd0, d); chk("R5 normal pend 6/8", d, 16'h00A0);
    @(negedge clk); n6 = 1; n8 = 1; settle(6);

    // R6 fast-only input and mask width
    wr_reg(4'd6, 16'hFFFF);
    rd_reg(4'd6, d); chk("R6 fast enable width", d, 16'h000F);
    @(negedge clk); i9 = 1; settle(6);
    rd_reg(4'd4, d); chk("R6 in9 fast bit3", d, 16'h0008);
    rd_reg(4'd0, d); chk("R6 in9 not normal", d, 0);
    chk("R6 fiq raised", fiq, 1);
    @(negedge clk); i9 = 0; settle(6);

    // R7 port
    wr_reg(4'd9, 16'h00A5); wr_reg(4'd10, 16'h003C);
    chk("R7 port out", port_out, 8'hA5);
    chk("R7 port oe", port_oe, 8'h3C);
    @(negedge clk); port_in = 8'h81; settle(6);
    rd_reg(4'd0, d); chk("R7 port pend", d, 16'h8100);
    rd_reg(4'd8, d); chk("R7 raw port", d[15:8], 8'h81);
    @(negedge clk); port_in = 8'h00; settle(6);

    // R8 open-drain
    wr_reg(4'd11, 16'h0002);
    chk("R8 od drive", od_low, 2'b10);
    @(negedge clk); od_in = 2'b01; settle(6);
    rd_reg(4'd8, d); chk("R8 raw od", d[2:1], 2'b01);
    rd_reg(4'd0, d); chk("R8 no normal source", d, 0);
    rd_reg(4'd4, d); chk("R8 no fast source", d, 0);
    chk("R8 no irq", irq, 0);
    @(negedge clk); od_in = 2'b11; settle(6);

    // R10 wake
    wcnt = 0;
    @(negedge clk); ev1 = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (wake) wcnt++; end
    chk("R10 ev1 one pulse", wcnt, 1);
    wcnt = 0;
    @(negedge clk); ev1 = 1;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (wake) wcnt++; end
    chk("R10 rise no pulse", wcnt, 0);
    wcnt = 0;
    @(negedge clk); ev2 = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (wake) wcnt++; end
    chk("R10 ev2 one pulse", wcnt, 1);
    @(negedge clk); ev2 = 1; settle(6);

    // random mix: R2 R3 R4 R5 R6 R7 R9
    wr_reg(4'd1, 16'hFFFF);
    e1_exp = 0; e2_exp = 0;
    for (int it = 0; it < 80; it++) begin
      logic [31:0] r;
      logic [15:0] im, fm, cl;
      logic old1, old2;
      r = $urandom; im = r[15:0]; fm = r[31:16];
      wr_reg(4'd2, im); wr_reg(4'd6, fm);
      old1 = n1; old2 = i2;
      r = $urandom;
      @(negedge clk);
      n1 = r[0]; i2 = r[1]; n3 = r[2]; n4 = r[3]; i5 = r[4];
      n6 = r[5]; i7 = r[6]; n8 = r[7]; i9 = r[8]; port_in = r[23:16];
      od_in = r[25:24];
      if (old1 && !n1) e1_exp = 1;
      if (!old2 && i2) e2_exp = 1;
      settle(6);
      if (r[31]) begin
        cl = 16'($urandom);
        wr_reg(4'd1, cl);
        if (cl[0]) e1_exp = 0;
        if (cl[1]) e2_exp = 0;
      end
      settle(2);
      rd_reg(4'd0, d); chk("R2 R3 R4 R7 rand normal pend", d, exp_irq());
      rd_reg(4'd4, d); chk("R5 R6 rand fast pend", d, exp_fiq());
      rd_reg(4'd3, d); chk("R9 rand normal req", d, exp_irq() & im);
      rd_reg(4'd7, d); chk("R9 rand fast req", d, exp_fiq() & {12'h000, fm[3:0]});
      chk("R9 rand irq_o", irq, |(exp_irq() & im));
      chk("R9 rand fiq_o", fiq, |(exp_fiq() & {12'h000, fm[3:0]}));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule